// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, for each received CAN frame, whether the frame is kept and into which of two receive queues it goes. It holds a parameterised set of filter banks. Each bank has two 32-bit words plus four per-bank configuration bits: list/mask mode, wide/narrow scale, queue select and enable. Depending on mode and scale, a bank acts as one masked or two exact 32-bit filters, or as two masked or four exact 16-bit filters.

Configuration is written through a single-cycle write port. A 6-bit split value shares the banks between two controllers: banks below the split serve controller 0, and banks at or above it serve controller 1. A frame is presented as a 29-bit identifier with its IDE and RTR flags and the controller it came from. One cycle later the block returns a registered verdict: accept, the target queue, and the index of the filter entry that matched.

Frame reception and queue storage sit outside this block. NUM_BANKS may be at most 32, because each bitmap is written as one data word.

Top module: `can_accept_filter`

## Requirements
- R1: A frame presented with `frm_valid` high at a rising edge gives `res_valid` high for exactly the following cycle. `res_valid` is low in every other cycle, and `res_accept` is never high while `res_valid` is low.
- R2: After reset all banks are disabled, so no frame is accepted. The split resets to RST_SPLIT (default NUM_BANKS, which gives every bank to controller 0).
- R3: Wide image: identifier in bits [31:3], IDE in bit 2, RTR in bit 1, bit 0 ignored. A standard identifier occupies bits [31:21]. In wide mask mode, word 1 is the identifier and word 2 the mask. A mask bit of 1 forces the frame bit to equal the identifier bit; a mask bit of 0 is don't-care.
- R4: In wide list mode, word 1 and word 2 are two exact identifiers, forming entry 0 and entry 1 of the bank.
- R5: Narrow image: standard identifier in bits [15:5], RTR in bit 4, IDE in bit 3, and extended identifier bits [17:15] in bits [2:0] (zero for standard frames). In narrow mask mode, each word is one filter, with the mask in [31:16] and the identifier in [15:0]. Word 1 is entry 0 and word 2 is entry 1.
- R6: In narrow list mode, the four half-words are exact identifiers. Entries 0 to 3 are word 1 low, word 1 high, word 2 low and word 2 high.
- R7: A disabled bank never matches, but it keeps its contents and its entries are still counted in the match index.
- R8: `res_fifo` equals the queue-select bit of the winning bank.
- R9: Controller 0 (`frm_ctrl`=0) sees only banks below the split. Controller 1 sees only banks at or above it.
- R10: When several filters match, the lowest bank wins, and within that bank the lowest entry wins.
- R11: `res_index` is the number of entries in all banks that the controller owns below the winner, counted from that controller's first bank, plus the winner's entry number. A bank holds 1, 2, 2 or 4 entries for wide mask, wide list, narrow mask and narrow list.
- R12: A frame that no filter accepts gives `res_accept`=0, `res_fifo`=0 and `res_index`=0.
- R13: Write addresses: 2b is word 1 and 2b+1 is word 2 of bank b. Bitmaps sit at C=2*NUM_BANKS: C is mode (1=list), C+1 is scale (1=wide), C+2 is queue select, C+3 is enable, with bit b for bank b. C+4 holds the split in bits [5:0]. Other addresses are ignored. A write affects frames presented from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| frm_valid | input | 1 | Frame present this cycle |
| frm_ctrl | input | 1 | Controller the frame belongs to |
| frm_id | input | 29 | Identifier (standard in [10:0]) |
| frm_ide | input | 1 | Extended identifier flag |
| frm_rtr | input | 1 | Remote request flag |
| res_valid | output | 1 | Verdict present |
| res_accept | output | 1 | Frame accepted |
| res_fifo | output | 1 | Target queue |
| res_index | output | IDX_W | Matching filter entry number |

## Verification
The checks assume that `frm_valid` is a plain per-cycle qualifier, so any frame pattern is legal. They also assume the split only changes through the write port, which makes the verdict of a frame depend only on configuration written in earlier cycles. The assertions take the index bound from the fact that a bank never holds more than four entries. The stimulus presents single frames separated by idle cycles and writes only inside the address map, plus one deliberate write outside it. It uses extended identifiers up to 29 bits and standard ones up to 11 bits, so every image bit that a filter compares is defined.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

  typedef struct packed {
    logic [28:0] id;
    logic        ide;
    logic        rtr;
  } frame_t;

  // Wide comparison image of a frame
  function automatic logic [31:0] wide_image(frame_t f);
    if (f.ide) return {f.id, 1'b1, f.rtr, 1'b0};
    else       return {f.id[10:0], 18'd0, 1'b0, f.rtr, 1'b0};
  endfunction

  // Narrow comparison image of a frame
  function automatic logic [15:0] narrow_image(frame_t f);
    logic [10:0] std_part;
    logic [2:0]  ext_top;
    std_part = f.ide ? f.id[28:18] : f.id[10:0];
    ext_top  = f.ide ? f.id[17:15] : 3'd0;
    return {std_part, f.rtr, f.ide, ext_top};
  endfunction

endpackage

// File: rtl/flt_cfg_regs.sv
module flt_cfg_regs #(
  parameter int NUM_BANKS = 14,
  parameter int ADDR_W    = 6,
  parameter int RST_SPLIT = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [31:0]                  wr_data,
  output logic [NUM_BANKS-1:0][31:0]   word1_q,
  output logic [NUM_BANKS-1:0][31:0]   word2_q,
  output logic [NUM_BANKS-1:0]         list_q,
  output logic [NUM_BANKS-1:0]         wide_q,
  output logic [NUM_BANKS-1:0]         fifo_q,
  output logic [NUM_BANKS-1:0]         enable_q,
  output logic [5:0]                   split_q
);
  localparam int CFG_BASE = 2 * NUM_BANKS;

  int addr_i;
  assign addr_i = int'(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      word1_q  <= '0;
      word2_q  <= '0;
      list_q   <= '0;
      wide_q   <= '0;
      fifo_q   <= '0;
      enable_q <= '0;
      split_q  <= 6'(RST_SPLIT);
    end else if (wr_en) begin
      if (addr_i < CFG_BASE) begin
        if (wr_addr[0]) word2_q[addr_i / 2] <= wr_data;
        else            word1_q[addr_i / 2] <= wr_data;
      end else begin
        case (addr_i - CFG_BASE)
          0: list_q   <= wr_data[NUM_BANKS-1:0];
          1: wide_q   <= wr_data[NUM_BANKS-1:0];
          2: fifo_q   <= wr_data[NUM_BANKS-1:0];
          3: enable_q <= wr_data[NUM_BANKS-1:0];
          4: split_q  <= wr_data[5:0];
          default: ;
        endcase
      end
    end
  end

  // Split only moves on a write
  assert_split_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(split_q));

  // First cycle after reset: every bank disabled
  assert_reset_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (enable_q == '0));

endmodule

// File: rtl/flt_bank_match.sv
module flt_bank_match (
  input  logic [31:0] word1,
  input  logic [31:0] word2,
  input  logic        list_mode,
  input  logic        wide_mode,
  input  logic [31:0] img_w,
  input  logic [15:0] img_n,
  output logic [3:0]  hit
);
  logic [31:0] diff1, diff2;
  assign diff1 = img_w ^ word1;
  assign diff2 = img_w ^ word2;

  always_comb begin
    hit = 4'b0000;
    unique case ({wide_mode, list_mode})
      2'b10: hit[0] = ((diff1 & word2 & 32'hFFFF_FFFE) == 32'd0);
      2'b11: begin
        hit[0] = (diff1[31:1] == 31'd0);
        hit[1] = (diff2[31:1] == 31'd0);
      end
      2'b00: begin
        hit[0] = (((img_n ^ word1[15:0]) & word1[31:16]) == 16'd0);
        hit[1] = (((img_n ^ word2[15:0]) & word2[31:16]) == 16'd0);
      end
      default: begin
        hit[0] = (img_n == word1[15:0]);
        hit[1] = (img_n == word1[31:16]);
        hit[2] = (img_n == word2[15:0]);
        hit[3] = (img_n == word2[31:16]);
      end
    endcase
  end
endmodule

// File: rtl/flt_select.sv
module flt_select #(
  parameter int NUM_BANKS = 14,
  parameter int IDX_W     = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_valid,
  input  logic                       ctrl_sel,
  input  logic [5:0]                 split,
  input  logic [NUM_BANKS-1:0][3:0]  hits,
  input  logic [NUM_BANKS-1:0]       list_mode,
  input  logic [NUM_BANKS-1:0]       wide_mode,
  input  logic [NUM_BANKS-1:0]       fifo_sel,
  input  logic [NUM_BANKS-1:0]       enable,
  output logic                       res_valid,
  output logic                       res_accept,
  output logic                       res_fifo,
  output logic [IDX_W-1:0]           res_index
);
  localparam int CNT_W = $clog2(4 * NUM_BANKS + 1);

  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] win_idx;
  logic             found;
  logic             win_fifo;

  always_comb begin
    run_cnt  = '0;
    win_idx  = '0;
    found    = 1'b0;
    win_fifo = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (ctrl_sel ? (b >= int'(split)) : (b < int'(split))) begin
        if (!found && enable[b] && (|hits[b])) begin
          found    = 1'b1;
          win_fifo = fifo_sel[b];
          if      (hits[b][0]) win_idx = run_cnt;
          else if (hits[b][1]) win_idx = run_cnt + CNT_W'(1);
          else if (hits[b][2]) win_idx = run_cnt + CNT_W'(2);
          else                 win_idx = run_cnt + CNT_W'(3);
        end
        case ({wide_mode[b], list_mode[b]})
          2'b10:   run_cnt = run_cnt + CNT_W'(1);
          2'b01:   run_cnt = run_cnt + CNT_W'(4);
          default: run_cnt = run_cnt + CNT_W'(2);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_fifo   <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid  <= frame_valid;
      res_accept <= frame_valid && found;
      res_fifo   <= frame_valid && found && win_fifo;
      res_index  <= (frame_valid && found) ? win_idx[IDX_W-1:0] : '0;
    end
  end

  assert_verdict_follows_R1: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> res_valid);

  assert_no_spurious_verdict_R1: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |=> (!res_valid && !res_accept));

  assert_reject_clean_R12: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_accept) |-> (res_index == '0 && !res_fifo));

  assert_index_bound_R11: assert property (@(posedge clk) disable iff (rst)
    res_accept |-> (int'(res_index) < 4 * NUM_BANKS));

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import can_flt_pkg::*;
#(
  parameter int NUM_BANKS = 14,
  parameter int RST_SPLIT = NUM_BANKS,
  parameter int ADDR_W    = $clog2(2 * NUM_BANKS + 5),
  parameter int IDX_W     = $clog2(4 * NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              frm_valid,
  input  logic              frm_ctrl,
  input  logic [28:0]       frm_id,
  input  logic              frm_ide,
  input  logic              frm_rtr,
  output logic              res_valid,
  output logic              res_accept,
  output logic              res_fifo,
  output logic [IDX_W-1:0]  res_index
);
  logic [NUM_BANKS-1:0][31:0] word1, word2;
  logic [NUM_BANKS-1:0]       list_mode, wide_mode, fifo_sel, enable;
  logic [5:0]                 split;
  logic [NUM_BANKS-1:0][3:0]  hits;
  frame_t                     frm;
  logic [31:0]                img_w;
  logic [15:0]                img_n;

  assign frm   = '{id: frm_id, ide: frm_ide, rtr: frm_rtr};
  assign img_w = wide_image(frm);
  assign img_n = narrow_image(frm);

  flt_cfg_regs #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .RST_SPLIT(RST_SPLIT)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .word1_q(word1), .word2_q(word2),
    .list_q(list_mode), .wide_q(wide_mode), .fifo_q(fifo_sel),
    .enable_q(enable), .split_q(split)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    flt_bank_match u_match (
      .word1(word1[b]), .word2(word2[b]),
      .list_mode(list_mode[b]), .wide_mode(wide_mode[b]),
      .img_w(img_w), .img_n(img_n),
      .hit(hits[b])
    );
  end

  flt_select #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst),
    .frame_valid(frm_valid), .ctrl_sel(frm_ctrl), .split(split),
    .hits(hits), .list_mode(list_mode), .wide_mode(wide_mode),
    .fifo_sel(fifo_sel), .enable(enable),
    .res_valid(res_valid), .res_accept(res_accept),
    .res_fifo(res_fifo), .res_index(res_index)
  );

endmodule

// File: tb/can_accept_filter_tb.sv
module can_accept_filter_tb;
  localparam int NB      = 14;
  localparam int AW      = 6;
  localparam int A_MODE  = 2 * NB;
  localparam int A_SCALE = 2 * NB + 1;
  localparam int A_FIFO  = 2 * NB + 2;
  localparam int A_EN    = 2 * NB + 3;
  localparam int A_SPLIT = 2 * NB + 4;

  logic clk = 0, rst = 1;
  logic cfg_wr_en = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic frm_valid = 0, frm_ctrl = 0, frm_ide = 0, frm_rtr = 0;
  logic [28:0] frm_id = '0;
  logic res_valid, res_accept, res_fifo;
  logic [5:0] res_index;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  can_accept_filter u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_ctrl(frm_ctrl),
    .frm_id(frm_id), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
    .res_valid(res_valid), .res_accept(res_accept), .res_fifo(res_fifo),
    .res_index(res_index)
  );

  function automatic logic [31:0] w_img(logic [28:0] id, bit ide, bit rtr);
    return ide ? {id, 1'b1, rtr, 1'b0} : {id[10:0], 18'd0, 1'b0, rtr, 1'b0};
  endfunction

  function automatic logic [15:0] n_img(logic [28:0] id, bit ide, bit rtr);
    return ide ? {id[28:18], rtr, 1'b1, id[17:15]} : {id[10:0], rtr, 1'b0, 3'd0};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1; cfg_addr = AW'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic send(bit ctrl, logic [28:0] id, bit ide, bit rtr,
                      bit e_acc, bit e_fifo, int e_idx, string req);
    @(negedge clk);
    frm_valid = 1; frm_ctrl = ctrl; frm_id = id; frm_ide = ide; frm_rtr = rtr;
    @(negedge clk);
    frm_valid = 0;
    check({req, " valid"}, res_valid, 1);
    check({req, " accept"}, res_accept, e_acc);
    check({req, " fifo"}, res_fifo, e_fifo);
    check({req, " index"}, res_index, e_idx);
    @(negedge clk);
    check("R1 idle after verdict", {res_valid, res_accept}, 0);
  endtask

  task automatic t_reset();
    check("R1 idle at reset", res_valid, 0);
    send(0, 29'h123, 0, 0, 0, 0, 0, "R2 no bank enabled");
  endtask

  task automatic t_wide_mask();
    wr(0, w_img(29'h1234567, 1, 0));
    wr(1, 32'hFFFF_FF06);
    wr(A_MODE, 0); wr(A_SCALE, 1); wr(A_FIFO, 0); wr(A_EN, 1);
    send(0, 29'h1234567, 1, 0, 1, 0, 0, "R3 exact hit");
    send(0, 29'h123457F, 1, 0, 1, 0, 0, "R3 dont-care bits");
    send(0, 29'h1234667, 1, 0, 0, 0, 0, "R3 masked bit differs");
    send(0, 29'h567, 0, 0, 0, 0, 0, "R3 IDE differs");
    send(1, 29'h1234567, 1, 0, 0, 0, 0, "R2 reset split gives ctrl1 nothing");
  endtask

  task automatic t_wide_list();
    wr(0, w_img(29'h123, 0, 0));
    wr(1, w_img(29'h1ABCDEF, 1, 1));
    wr(A_MODE, 1);
    send(0, 29'h123, 0, 0, 1, 0, 0, "R4 entry0");
    send(0, 29'h1ABCDEF, 1, 1, 1, 0, 1, "R4 entry1");
    send(0, 29'h1ABCDEF, 1, 0, 0, 0, 0, "R4 RTR differs");
  endtask

  task automatic t_narrow_mask();
    wr(0, {16'hFFF8, n_img(29'h2A5, 0, 0)});
    wr(1, {16'hFFFF, n_img(29'h5568123, 1, 0)});
    wr(A_MODE, 0); wr(A_SCALE, 0);
    send(0, 29'h2A5, 0, 0, 1, 0, 0, "R5 std entry0");
    send(0, 29'h5568123, 1, 0, 1, 0, 1, "R5 ext entry1");
    send(0, 29'h5568456, 1, 0, 1, 0, 1, "R5 low ext bits outside image");
    send(0, 29'h5560123, 1, 0, 0, 0, 0, "R5 ext top bits differ");
    send(0, 29'h2A5, 0, 1, 0, 0, 0, "R5 RTR masked mismatch");
  endtask

  task automatic t_narrow_list();
    wr(0, {n_img(29'h101, 0, 0), n_img(29'h100, 0, 0)});
    wr(1, {n_img(29'h103, 0, 0), n_img(29'h102, 0, 0)});
    wr(A_MODE, 1);
    for (int k = 0; k < 4; k++)
      send(0, 29'h100 + 29'(k), 0, 0, 1, 0, k, "R6 entry order");
    send(0, 29'h104, 0, 0, 0, 0, 0, "R6 no entry");
  endtask

  task automatic t_disable();
    wr(A_EN, 0);
    send(0, 29'h102, 0, 0, 0, 0, 0, "R7 disabled bank");
    wr(A_EN, 1);
    send(0, 29'h102, 0, 0, 1, 0, 2, "R7 contents kept");
  endtask

  task automatic t_priority();
    wr(2, 0); wr(3, 0);
    wr(A_MODE, 1); wr(A_SCALE, 2); wr(A_FIFO, 2); wr(A_EN, 3);
    send(0, 29'h101, 0, 0, 1, 0, 1, "R10 lower bank wins");
    send(0, 29'h7FF, 0, 0, 1, 1, 4, "R8 R11 second bank");
    wr(A_EN, 2);
    send(0, 29'h101, 0, 0, 1, 1, 4, "R7 R11 disabled bank still counted");
    wr(4, w_img(29'h055, 0, 0)); wr(5, w_img(29'h055, 0, 0));
    wr(A_MODE, 5); wr(A_SCALE, 6); wr(A_EN, 4);
    send(0, 29'h055, 0, 0, 1, 0, 5, "R10 R11 lowest entry in bank");
  endtask

  task automatic t_split();
    wr(A_MODE, 1); wr(A_SCALE, 2); wr(A_FIFO, 2); wr(A_EN, 3);
    wr(A_SPLIT, 1);
    send(0, 29'h7FF, 0, 0, 0, 0, 0, "R9 R12 ctrl0 cannot see bank1");
    send(1, 29'h7FF, 0, 0, 1, 1, 0, "R9 R11 ctrl1 counts from split");
    send(1, 29'h101, 0, 0, 1, 1, 0, "R9 ctrl1 cannot see bank0");
    send(0, 29'h101, 0, 0, 1, 0, 1, "R9 ctrl0 bank0");
    wr(A_SPLIT, 0);
    send(0, 29'h101, 0, 0, 0, 0, 0, "R9 split zero ctrl0 owns none");
    send(1, 29'h101, 0, 0, 1, 0, 1, "R9 split zero ctrl1 owns all");
  endtask

  task automatic t_addr_map();
    wr(A_SPLIT + 1, 32'hFFFF_FFFF);
    send(1, 29'h101, 0, 0, 1, 0, 1, "R13 unused address ignored");
    @(negedge clk);
    cfg_wr_en = 1; cfg_addr = AW'(A_EN); cfg_wdata = 0;
    frm_valid = 1; frm_ctrl = 1; frm_id = 29'h101; frm_ide = 0; frm_rtr = 0;
    @(negedge clk);
    cfg_wr_en = 0; frm_valid = 0;
    check("R13 write applies from next edge", res_accept, 1);
    send(1, 29'h101, 0, 0, 0, 0, 0, "R13 write now in effect");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_wide_mask();
    t_wide_list();
    t_narrow_mask();
    t_narrow_list();
    t_disable();
    t_priority();
    t_split();
    t_addr_map();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule